// File: doc/BRIEF.md
# Two-Pass Feistel Round Function Unit

This unit evaluates the 64-bit round function of a 128-bit Feistel block cipher while building only four byte substitution boxes instead of eight. A caller presents a 64-bit data half and a 64-bit round key with a one-cycle `start` strobe. The unit XORs the key into the data and latches the result. It then runs two passes over the same four-box substitution row, one for each 4-byte group of the mixed word. Each pass feeds a byte-level XOR diffusion layer whose other byte inputs are held at zero. The first pass's 64-bit diffusion result is kept in an accumulator and XORed with the second pass's result. Because the diffusion layer is linear, the sum equals the full eight-box round function.

The result appears on `dout` together with a one-cycle `done` pulse, and `dout` keeps it until the next result. The unit takes one new operation whenever it is idle. Strobes that arrive while it is working are dropped. The cipher's round sequencing, its extra mixing layers and its key expansion belong to the surrounding design.

Top module: `feistel_fold_top`

## Requirements
- R1: The substitution input is `din ^ key`. Bytes are numbered x1 (bits 63:56) through x8 (bits 7:0) of this mixed word.
- R2: The base box B(v) is the multiplicative inverse of v in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0, XORed with the parameter `SBOX_OFFSET` (default 8'h6E). The four boxes are defined from B: box 1 = B(v), box 2 = rotl1(B(v)), box 3 = rotr1(B(v)) and box 4 = B(rotl1(v)).
- R3: Only four boxes exist, and they are ordered 1, 4, 3, 2. The first pass feeds them x8, x7, x6, x5. The second pass feeds them x1, x4, x3, x2. Together the passes give x1..x8 the boxes 1,2,3,4,2,3,4,1.
- R4: The diffusion layer takes the box outputs z1..z8, with z1 the most significant byte, and produces y1..y8 (y1 in bits 63:56):
  - y1 = z1^z3^z4^z6^z7^z8
  - y2 = z1^z2^z4^z5^z7^z8
  - y3 = z1^z2^z3^z5^z6^z8
  - y4 = z2^z3^z4^z5^z6^z7
  - y5 = z1^z2^z6^z7^z8
  - y6 = z2^z3^z5^z7^z8
  - y7 = z3^z4^z5^z6^z8
  - y8 = z1^z4^z5^z6^z7
- R5: `dout` equals the XOR of the two passes' diffusion outputs. Each pass's output is computed with the bytes not fed in that pass set to zero. The XOR equals the eight-box function defined by R1–R4.
- R6: A `start` sampled high while idle is accepted. `done` then goes high for exactly one cycle after the third rising edge, counting the accepting edge as the first. A `start` sampled in the `done` cycle is accepted.
- R7: A `start` sampled high on the two edges after an accepted one is ignored. It does not change the result in flight or its timing.
- R8: After reset, `dout` is 0 and `done` is 0. `dout` changes only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (accepted only when idle) |
| din | input | 64 | Data half, sampled with an accepted start |
| key | input | 64 | Round key, sampled with an accepted start |
| dout | output | 64 | Round function result, held until the next result |
| done | output | 1 | One-cycle pulse marking a new dout |

## Verification
The bench builds the unit with the default `SBOX_OFFSET` of 8'h6E. This offset keeps every box output nonzero for a zero input, so a zero mixed word still tests the diffusion sums and the box order. Single-byte mixed words separate the two passes and expose a swapped lane or pass. Long held strobes and strobes in the `done` cycle test the idle-only acceptance rule against a cycle-level reference model.

// File: rtl/feistel_fold_pkg.sv
package feistel_fold_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 8;
  localparam int LANES      = NUM_BYTES / 2;
  localparam int WORD_W     = BYTE_W * NUM_BYTES;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;
    logic firstPass;
    logic secondPass;
  } ctl_t;

  // box kind per lane: lanes use boxes 1,4,3,2 (coded 0,3,2,1)
  function automatic int laneKind(input int lane);
    case (lane)
      0:       return 0;
      1:       return 3;
      2:       return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/fold_sbox.sv
module fold_sbox #(
  parameter int KIND = 0,
  parameter logic [7:0] SBOX_OFFSET = 8'h6E
) (
  input  logic [7:0] inByte,
  output logic [7:0] outByte
);
  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = {t[6:0], 1'b0} ^ (t[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // v^254 by square-and-multiply, gives 0 for 0
  function automatic logic [7:0] gfInv(input logic [7:0] v);
    logic [7:0] sq;
    logic [7:0] prod;
    sq = v;
    prod = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq = gfMul(sq, sq);
      prod = gfMul(prod, sq);
    end
    return prod;
  endfunction

  logic [7:0] preByte;
  logic [7:0] baseOut;

  generate
    if (KIND == 3) begin : g_rot_in
      assign preByte = {inByte[6:0], inByte[7]};
    end else begin : g_plain_in
      assign preByte = inByte;
    end
  endgenerate

  assign baseOut = gfInv(preByte) ^ SBOX_OFFSET;

  generate
    if (KIND == 1) begin : g_rotl_out
      assign outByte = {baseOut[6:0], baseOut[7]};
    end else if (KIND == 2) begin : g_rotr_out
      assign outByte = {baseOut[0], baseOut[7:1]};
    end else begin : g_plain_out
      assign outByte = baseOut;
    end
  endgenerate
endmodule

// File: rtl/fold_diffuse.sv
module fold_diffuse
  import feistel_fold_pkg::*;
(
  input  logic [WORD_W-1:0] zIn,
  output logic [WORD_W-1:0] yOut
);
  logic [BYTE_W-1:0] z [1:NUM_BYTES];
  logic [BYTE_W-1:0] y [1:NUM_BYTES];

  generate
    for (genvar k = 1; k <= NUM_BYTES; k++) begin : g_split
      assign z[k] = zIn[WORD_W - BYTE_W*(k-1) - 1 -: BYTE_W];
      assign yOut[WORD_W - BYTE_W*(k-1) - 1 -: BYTE_W] = y[k];
    end
  endgenerate

  always_comb begin
    y[1] = z[1] ^ z[3] ^ z[4] ^ z[6] ^ z[7] ^ z[8];
    y[2] = z[1] ^ z[2] ^ z[4] ^ z[5] ^ z[7] ^ z[8];
    y[3] = z[1] ^ z[2] ^ z[3] ^ z[5] ^ z[6] ^ z[8];
    y[4] = z[2] ^ z[3] ^ z[4] ^ z[5] ^ z[6] ^ z[7];
    y[5] = z[1] ^ z[2] ^ z[6] ^ z[7] ^ z[8];
    y[6] = z[2] ^ z[3] ^ z[5] ^ z[7] ^ z[8];
    y[7] = z[3] ^ z[4] ^ z[5] ^ z[6] ^ z[8];
    y[8] = z[1] ^ z[4] ^ z[5] ^ z[6] ^ z[7];
  end
endmodule

// File: rtl/fold_datapath.sv
module fold_datapath
  import feistel_fold_pkg::*;
#(
  parameter logic [7:0] SBOX_OFFSET = 8'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] key,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] mixedReg;
  logic [WORD_W-1:0] accReg;
  logic [WORD_W-1:0] doutReg;
  logic [WORD_W-1:0] zVec;
  logic [WORD_W-1:0] yVec;
  logic [BYTE_W-1:0] laneIn  [LANES];
  logic [BYTE_W-1:0] laneOut [LANES];

  // byte k of mixed word (k = 1 is the top byte)
  function automatic logic [BYTE_W-1:0] xByte(input logic [WORD_W-1:0] w, input int k);
    return w[WORD_W - BYTE_W*(k-1) - 1 -: BYTE_W];
  endfunction

  // pass byte per lane: first pass x8,x7,x6,x5; second pass x1,x4,x3,x2
  function automatic int laneByte(input int lane, input logic second);
    if (!second) return NUM_BYTES - lane;
    if (lane == 0) return 1;
    return LANES + 1 - lane;
  endfunction

  always_comb begin
    zVec = '0;
    for (int l = 0; l < LANES; l++) begin
      laneIn[l] = xByte(mixedReg, laneByte(l, ctl.secondPass));
      zVec[WORD_W - BYTE_W*(laneByte(l, ctl.secondPass)-1) - 1 -: BYTE_W] = laneOut[l];
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      fold_sbox #(.KIND(laneKind(l)), .SBOX_OFFSET(SBOX_OFFSET)) u_box (
        .inByte (laneIn[l]),
        .outByte(laneOut[l])
      );
    end
  endgenerate

  fold_diffuse u_diff (
    .zIn (zVec),
    .yOut(yVec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mixedReg <= '0;
      accReg   <= '0;
      doutReg  <= '0;
    end else begin
      if (ctl.load)       mixedReg <= din ^ key;
      if (ctl.firstPass)  accReg   <= yVec;
      if (ctl.secondPass) doutReg  <= accReg ^ yVec;
    end
  end

  assign dout = doutReg;

  // R8: result register moves only on the second pass
  a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.secondPass |=> $stable(doutReg));

  // R5: partial sum is only taken on the first pass
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.firstPass |=> $stable(accReg));

  // R7: operand latch frozen while a pass runs
  a_r7_operand_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.firstPass || ctl.secondPass) |=> $stable(mixedReg));
endmodule

// File: rtl/fold_control.sv
module fold_control
  import feistel_fold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output ctl_t ctl,
  output logic done
);
  phase_t phase;
  phase_t phaseNext;
  logic   doneReg;

  always_comb begin
    ctl.load       = start && (phase == PH_IDLE);
    ctl.firstPass  = (phase == PH_FIRST);
    ctl.secondPass = (phase == PH_SECOND);
    case (phase)
      PH_IDLE:   phaseNext = start ? PH_FIRST : PH_IDLE;
      PH_FIRST:  phaseNext = PH_SECOND;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      doneReg <= 1'b0;
    end else begin
      phase   <= phaseNext;
      doneReg <= ctl.secondPass;
    end
  end

  assign done = doneReg;

  // R6: an idle start opens the first pass
  a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == PH_IDLE) |=> (phase == PH_FIRST));

  // R6: first pass is always followed by the second
  a_r6_second: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST) |=> (phase == PH_SECOND));

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a busy start never restarts the sequence
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase != PH_FIRST));

  // R6: done only follows the second pass
  a_r6_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(phase == PH_SECOND));
endmodule

// File: rtl/feistel_fold_top.sv
module feistel_fold_top
  import feistel_fold_pkg::*;
#(
  parameter logic [7:0] SBOX_OFFSET = 8'h6E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] din,
  input  logic [63:0] key,
  output logic [63:0] dout,
  output logic        done
);
  ctl_t ctl;

  fold_control u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  fold_datapath #(.SBOX_OFFSET(SBOX_OFFSET)) u_dp (
    .clk  (clk),
    .rst_n(rst_n),
    .ctl  (ctl),
    .din  (din),
    .key  (key),
    .dout (dout)
  );
endmodule

// File: tb/feistel_fold_top_test.sv
module feistel_fold_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] din = '0;
  logic [63:0] key = '0;
  logic [63:0] dout;
  logic        done;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  bit checking = 0;
  string curTag = "R8";

  always #2 clk = ~clk;

  feistel_fold_top uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .din(din), .key(key), .dout(dout), .done(done)
  );

  // ---------------- reference model ----------------
  function automatic int refMul(input int a, input int b);
    int p = 0;
    int aa = a;
    int bb = b;
    while (bb != 0) begin
      if ((bb & 1) != 0) p = p ^ aa;
      aa = aa << 1;
      if ((aa & 'h100) != 0) aa = aa ^ 'h11B;
      bb = bb >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] refBase(input logic [7:0] v);
    int inv = 0;
    if (v != 0)
      for (int c = 1; c < 256; c++)
        if (refMul(int'(v), c) == 1) inv = c;
    return 8'(inv) ^ 8'h6E;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v);
    return {v[6:0], v[7]};
  endfunction

  function automatic logic [7:0] rr(input logic [7:0] v);
    return {v[0], v[7:1]};
  endfunction

  function automatic logic [63:0] refF(input logic [63:0] d, input logic [63:0] k);
    logic [63:0] m;
    logic [7:0] x [8];
    logic [7:0] z [8];
    logic [7:0] y [8];
    m = d ^ k;
    for (int i = 0; i < 8; i++) x[i] = m[63 - 8*i -: 8];
    z[0] = refBase(x[0]);
    z[1] = rl(refBase(x[1]));
    z[2] = rr(refBase(x[2]));
    z[3] = refBase(rl(x[3]));
    z[4] = rl(refBase(x[4]));
    z[5] = rr(refBase(x[5]));
    z[6] = refBase(rl(x[6]));
    z[7] = refBase(x[7]);
    y[0] = z[0]^z[2]^z[3]^z[5]^z[6]^z[7];
    y[1] = z[0]^z[1]^z[3]^z[4]^z[6]^z[7];
    y[2] = z[0]^z[1]^z[2]^z[4]^z[5]^z[7];
    y[3] = z[1]^z[2]^z[3]^z[4]^z[5]^z[6];
    y[4] = z[0]^z[1]^z[5]^z[6]^z[7];
    y[5] = z[1]^z[2]^z[4]^z[6]^z[7];
    y[6] = z[2]^z[3]^z[4]^z[5]^z[7];
    y[7] = z[0]^z[3]^z[4]^z[5]^z[6];
    return {y[0], y[1], y[2], y[3], y[4], y[5], y[6], y[7]};
  endfunction

  int          busyLeft = 0;
  logic [63:0] pending = '0;
  logic        expDone = 1'b0;
  logic [63:0] expDout = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busyLeft <= 0;
      expDone  <= 1'b0;
      expDout  <= '0;
    end else begin
      expDone <= 1'b0;
      if (busyLeft == 1) begin
        busyLeft <= 0;
        expDone  <= 1'b1;
        expDout  <= pending;
      end else if (busyLeft == 2) begin
        busyLeft <= 1;
      end else if (start) begin
        busyLeft <= 2;
        pending  <= refF(din, key);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checking && !finished) begin
      testsRun++;
      if (done !== expDone) begin
        testsFailed++;
        $display("FAIL %s (R6 done timing): actual %0b expected %0b", curTag, done, expDone);
      end
      testsRun++;
      if (dout !== expDout) begin
        testsFailed++;
        $display("FAIL %s (R5 dout value): actual %h expected %h", curTag, dout, expDout);
      end
    end
  end

  task automatic issue(input logic [63:0] d, input logic [63:0] k);
    @(negedge clk);
    start = 1'b1; din = d; key = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    curTag = "R8";
    testsRun++;
    if (dout !== 64'h0 || done !== 1'b0) begin
      testsFailed++;
      $display("FAIL R8 reset: actual %h/%0b expected 0/0", dout, done);
    end
    checking = 1;

    // R1: key equal to data gives a zero mixed word
    curTag = "R1";
    issue(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
    waitIdle(4);
    issue(64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_F0F0_F0F0);
    waitIdle(4);

    // R2 / R3: single nonzero byte per position separates lanes and passes
    for (int pos = 0; pos < 8; pos++) begin
      curTag = (pos < 4) ? "R3" : "R2";
      issue(64'h80 << (8*pos), 64'h0);
      waitIdle(3);
      issue(64'h01 << (8*pos), 64'h0);
      waitIdle(3);
    end

    // R4: byte patterns exercising the diffusion sums
    curTag = "R4";
    issue(64'h0102_0408_1020_4080, 64'h0);
    waitIdle(3);
    issue(64'hFF00_FF00_00FF_00FF, 64'hA5A5_A5A5_5A5A_5A5A);
    waitIdle(3);

    // R5: random operands, idle gaps
    curTag = "R5";
    for (int n = 0; n < 120; n++) begin
      issue({$urandom, $urandom}, {$urandom, $urandom});
      waitIdle(n % 3);
    end

    // R7: start held high while busy with changing operands
    curTag = "R7";
    @(negedge clk);
    for (int n = 0; n < 15; n++) begin
      start = 1'b1;
      din = {$urandom, $urandom};
      key = {$urandom, $urandom};
      @(negedge clk);
    end
    start = 1'b0;
    waitIdle(4);

    // R6: start exactly in the done cycle, back to back
    curTag = "R6";
    issue(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    waitIdle(1);
    issue(64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_DEF0);
    waitIdle(1);
    issue(64'h0, 64'h0);
    waitIdle(5);

    checking = 0;
    finish();
  end
endmodule